// File: doc/BRIEF.md
# Keyed Reset-Pulse Generator

This block produces the external reset pulse that goes out when a watchdog expires, and it holds the single configuration register that shapes that pulse. The low field of the register sets the pulse length, counted in microsecond ticks. The counter adds one to the field, so a field of zero still gives a one-tick pulse. Two more settings choose the output polarity and the output drive style: push-pull, or open-drain emulated through an output enable.

The two output settings are guarded against stray writes. Each one changes only when one of its own key bytes appears in the top byte of a write. The width field is taken from every write, whatever the top byte holds.

The block has no timebase of its own. A 1 MHz tick strobe comes from outside, and so does the one-cycle expiry trigger. When a trigger arrives while the block is idle, a pulse starts and runs for the programmed number of ticks. A trigger that arrives during a pulse has no effect. The pad and the tick generator are outside this block.

Top module: `rstpulse_top`

## Requirements
- R1: After reset the width field is 0xFF, the polarity is active low and the drive style is open-drain. A read returns 0x000000FF, `pulseLevel` is 1 and `pulseOe` is 0.
- R2: Every write loads `wrData[19:0]` into the width field, whatever the top byte holds. The new value appears on `rdData[19:0]` from the next cycle.
- R3: When `expire` is high at a clock edge and no pulse is running, the pulse is asserted from that edge on. It stays asserted until the edge at which it has seen N+1 tick strobes, where N is the width. That edge ends it. With `tick` held high this gives N+1 cycles.
- R4: A write with top byte `wrData[31:24]` = 0xA5 makes the polarity active high. A write with 0x5A makes it active low.
- R5: A write with top byte 0xA8 selects push-pull drive. A write with 0x8A selects open-drain drive.
- R6: A write with any other top-byte value leaves polarity and drive style unchanged.
- R7: `rdData[31]` reads 1 when the polarity is active high, `rdData[30]` reads 1 for push-pull, and `rdData[29:20]` always reads 0.
- R8: While a pulse runs, `pulseLevel` equals the asserted level (1 for active high, 0 for active low). Otherwise it equals the opposite level.
- R9: In push-pull mode `pulseOe` is always 1. In open-drain mode `pulseOe` is 1 exactly when `pulseLevel` is 0.
- R10: An `expire` during a running pulse is ignored. The width is captured when the pulse starts, so a write during a pulse, or in the same cycle as the starting trigger, does not change that pulse's length. The next pulse uses the new width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data: key byte in [31:24], width in [19:0] |
| rdData | output | 32 | Register read value |
| tick | input | 1 | One-cycle 1 MHz tick strobe |
| expire | input | 1 | Watchdog expiry trigger |
| pulseLevel | output | 1 | Pulse output level |
| pulseOe | output | 1 | Output enable for the pulse pad |

## Verification
Pulses are measured with the tick held high for the default width, for width zero and for a small width. These show whether the counter loads N or N+1 and whether it stops at zero or wraps.

All four key bytes are written, along with a neutral top byte and an all-ones top byte. This separates key matching from the width load and from the padding bits.

A retrigger during a pulse, combined with a width write in the same cycle, shows whether the width is captured at the start of the pulse. A later run with sparse ticks, with polarity and drive flipped, compares the level and enable on every cycle against a behavioural model.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic load;   // capture the width into the down-counter
    logic dec;    // consume one tick
    logic on;     // pulse currently asserted
  } pulseCmd_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pulseState_t;

endpackage

// File: rtl/rstpulse_ctrl.sv
module rstpulse_ctrl
  import rstpulse_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      expire,
  input  logic      tick,
  input  logic      cntZero,
  output pulseCmd_t cmd
);

  pulseState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      ST_IDLE: begin
        if (expire) begin
          cmd.load  = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        cmd.on = 1'b1;
        if (tick) begin
          if (cntZero) stateNext = ST_IDLE;
          else         cmd.dec   = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/rstpulse_dp.sv
module rstpulse_dp
  import rstpulse_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 20,
  parameter logic [CNT_W-1:0] RST_WIDTH = 'hFF,
  parameter logic [7:0]  KEY_POL_HI = 8'hA5,
  parameter logic [7:0]  KEY_POL_LO = 8'h5A,
  parameter logic [7:0]  KEY_PP     = 8'hA8,
  parameter logic [7:0]  KEY_OD     = 8'h8A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  pulseCmd_t         cmd,
  output logic              cntZero,
  output logic [DATA_W-1:0] rdData,
  output logic              pulseLevel,
  output logic              pulseOe
);

  localparam int KEY_LSB = DATA_W - 8;
  localparam int PAD_W   = DATA_W - 2 - CNT_W;

  logic [CNT_W-1:0] widthReg;
  logic [CNT_W-1:0] cnt;
  logic             polHigh;
  logic             pushPull;
  logic [7:0]       keyByte;
  logic             unusedMid;

  assign keyByte   = wrData[DATA_W-1 -: 8];
  assign unusedMid = ^wrData[KEY_LSB-1:CNT_W];

  // Width field: every write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     widthReg <= RST_WIDTH;
    else if (wrEn) widthReg <= wrData[CNT_W-1:0];
  end

  // Polarity: only behind its keys
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) polHigh <= 1'b0;
    else if (wrEn) begin
      if (keyByte == KEY_POL_HI)      polHigh <= 1'b1;
      else if (keyByte == KEY_POL_LO) polHigh <= 1'b0;
    end
  end

  // Drive style: only behind its keys
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pushPull <= 1'b0;
    else if (wrEn) begin
      if (keyByte == KEY_PP)      pushPull <= 1'b1;
      else if (keyByte == KEY_OD) pushPull <= 1'b0;
    end
  end

  // Tick down-counter, loaded with the width at pulse start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.load) cnt <= widthReg;
    else if (cmd.dec)  cnt <= cnt - 1'b1;
  end

  assign cntZero    = (cnt == '0);
  assign rdData     = {polHigh, pushPull, {PAD_W{1'b0}}, widthReg};
  assign pulseLevel = cmd.on ~^ polHigh;
  assign pulseOe    = pushPull | ~pulseLevel;

endmodule

// File: rtl/rstpulse_top.sv
module rstpulse_top
  import rstpulse_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 20,
  parameter logic [CNT_W-1:0] RST_WIDTH = 'hFF,
  parameter logic [7:0]  KEY_POL_HI = 8'hA5,
  parameter logic [7:0]  KEY_POL_LO = 8'h5A,
  parameter logic [7:0]  KEY_PP     = 8'hA8,
  parameter logic [7:0]  KEY_OD     = 8'h8A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  input  logic              expire,
  output logic              pulseLevel,
  output logic              pulseOe
);

  pulseCmd_t cmd;
  logic      cntZero;

  rstpulse_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .expire  (expire),
    .tick    (tick),
    .cntZero (cntZero),
    .cmd     (cmd)
  );

  rstpulse_dp #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .RST_WIDTH  (RST_WIDTH),
    .KEY_POL_HI (KEY_POL_HI),
    .KEY_POL_LO (KEY_POL_LO),
    .KEY_PP     (KEY_PP),
    .KEY_OD     (KEY_OD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .cmd        (cmd),
    .cntZero    (cntZero),
    .rdData     (rdData),
    .pulseLevel (pulseLevel),
    .pulseOe    (pulseOe)
  );

endmodule

// File: rtl/rstpulse_chk.sv
module rstpulse_chk #(
  parameter int         DATA_W     = 32,
  parameter int         CNT_W      = 20,
  parameter logic [7:0] KEY_POL_HI = 8'hA5,
  parameter logic [7:0] KEY_POL_LO = 8'h5A,
  parameter logic [7:0] KEY_PP     = 8'hA8,
  parameter logic [7:0] KEY_OD     = 8'h8A
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              tick,
  input logic              expire,
  input logic              pulseLevel,
  input logic              pulseOe,
  input logic              pulseOn,
  input logic              cntZero
);

  logic [7:0] keyByte;
  logic       isKey;
  assign keyByte = wrData[DATA_W-1 -: 8];
  assign isKey   = (keyByte == KEY_POL_HI) || (keyByte == KEY_POL_LO) ||
                   (keyByte == KEY_PP) || (keyByte == KEY_OD);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!pulseOn && expire) |=> pulseOn);                                  // R3
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && !tick) |=> pulseOn);                                    // R3
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && tick && cntZero) |=> !pulseOn);                         // R3
  AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[CNT_W-1:0] == $past(wrData[CNT_W-1:0])));          // R2
  AST_POL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyByte == KEY_POL_HI) |=> rdData[DATA_W-1]);              // R4
  AST_POL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyByte == KEY_POL_LO) |=> !rdData[DATA_W-1]);             // R4
  AST_DRV_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyByte == KEY_PP) |=> rdData[DATA_W-2]);                  // R5
  AST_DRV_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && keyByte == KEY_OD) |=> !rdData[DATA_W-2]);                 // R5
  AST_KEEP_MODES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isKey) |=> $stable(rdData[DATA_W-1 -: 2]));               // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-3:CNT_W] == '0);                                      // R7
  AST_LEVEL_ON: assert property (@(posedge clk) disable iff (!rstN)
    pulseOn |-> (pulseLevel == rdData[DATA_W-1]));                      // R8
  AST_LEVEL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pulseOn |-> (pulseLevel != rdData[DATA_W-1]));                     // R8
  AST_OE_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-2] |-> pulseOe);                                      // R9
  AST_OE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[DATA_W-2] |-> (pulseOe == !pulseLevel));                    // R9
  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && expire && !cntZero) |=> pulseOn);                       // R10

endmodule

bind rstpulse_top rstpulse_chk #(
  .DATA_W     (DATA_W),
  .CNT_W      (CNT_W),
  .KEY_POL_HI (KEY_POL_HI),
  .KEY_POL_LO (KEY_POL_LO),
  .KEY_PP     (KEY_PP),
  .KEY_OD     (KEY_OD)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdData     (rdData),
  .tick       (tick),
  .expire     (expire),
  .pulseLevel (pulseLevel),
  .pulseOe    (pulseOe),
  .pulseOn    (cmd.on),
  .cntZero    (cntZero)
);

// File: tb/test_rstpulse_top.sv
`timescale 1ns/1ps
module test_rstpulse_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tick = 1'b0;
  logic        expire = 1'b0;
  logic        pulseLevel;
  logic        pulseOe;

  int checks = 0;
  int errors = 0;
  int tickDiv = 1;
  int tickPh = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rstpulse_top i_rstpulse_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .tick(tick), .expire(expire), .pulseLevel(pulseLevel), .pulseOe(pulseOe)
  );

  // ---------------- behavioural reference model ----------------
  int mWidth, mRemain;
  bit mPol, mDrv, mActive;

  always @(posedge clk) begin
    if (!rstN) begin
      mWidth = 'hFF; mPol = 0; mDrv = 0; mActive = 0; mRemain = 0;
    end else begin
      if (!mActive) begin
        if (expire) begin mActive = 1; mRemain = mWidth; end
      end else if (tick) begin
        if (mRemain == 0) mActive = 0;
        else mRemain = mRemain - 1;
      end
      if (wrEn) begin
        mWidth = int'(wrData[19:0]);
        case (wrData[31:24])
          8'hA5: mPol = 1;
          8'h5A: mPol = 0;
          8'hA8: mDrv = 1;
          8'h8A: mDrv = 0;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [31:0] eRd;
      bit eLvl, eOe;
      eRd  = {mPol, mDrv, 10'b0, 20'(mWidth)};
      eLvl = mPol ? mActive : !mActive;
      eOe  = mDrv | !eLvl;
      chk(rdData == eRd, "R2/R7 read value", rdData, eRd);
      chk(pulseLevel == eLvl, "R8 level", {31'b0, pulseLevel}, {31'b0, eLvl});
      chk(pulseOe == eOe, "R9 output enable", {31'b0, pulseOe}, {31'b0, eOe});
    end
  end

  // tick driver
  always @(negedge clk) begin
    tickPh = (tickPh + 1 >= tickDiv) ? 0 : tickPh + 1;
    tick <= (tickDiv == 1) ? 1'b1 : (tickPh == 0);
  end

  task automatic doWrite(input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrData = d;
    @(negedge clk); wrEn = 0; wrData = '0;
  endtask

  // fire expire and count cycles asserted; optionally retrigger + rewrite mid-pulse
  task automatic measure(input bit assertLvl, input bit retrig,
                         input logic [31:0] midData, output int len);
    @(negedge clk); expire = 1;
    @(negedge clk); expire = 0;
    len = 0;
    while (pulseLevel == assertLvl && len < 5000) begin
      len++;
      if (retrig && len == 2) begin expire = 1; wrEn = 1; wrData = midData; end
      else begin expire = 0; wrEn = 0; wrData = '0; end
      @(negedge clk);
    end
    expire = 0; wrEn = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin : stim
    int len;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(rdData == 32'h0000_00FF, "R1 reset read", rdData, 32'h0000_00FF);
    chk(pulseLevel == 1'b1, "R1 reset level", {31'b0, pulseLevel}, 32'h1);
    chk(pulseOe == 1'b0, "R1 reset oe", {31'b0, pulseOe}, 32'h0);

    // R3: default width 0xFF, tick every cycle -> 256 cycles
    measure(1'b0, 1'b0, '0, len);
    chk(len == 256, "R3 default length", len, 256);

    // R3: width 0 -> one tick
    doWrite(32'h0000_0000);
    measure(1'b0, 1'b0, '0, len);
    chk(len == 1, "R3 zero width", len, 1);

    // R4 + R7: active high key, width 3
    doWrite(32'hA500_0003);
    chk(rdData == 32'h8000_0003, "R4 polarity high", rdData, 32'h8000_0003);
    measure(1'b1, 1'b0, '0, len);
    chk(len == 4, "R3 width 3 active high", len, 4);

    // R5: push-pull key
    doWrite(32'hA800_0003);
    chk(rdData == 32'hC000_0003, "R5 push-pull", rdData, 32'hC000_0003);

    // R6: non-key top bytes keep modes, width still loads
    doWrite(32'h1200_0005);
    chk(rdData == 32'hC000_0005, "R6 neutral byte", rdData, 32'hC000_0005);
    doWrite(32'hFFFF_FFFF);
    chk(rdData == 32'hC00F_FFFF, "R6/R7 all-ones write", rdData, 32'hC00F_FFFF);

    // R4 / R5 back to low and open-drain
    doWrite(32'h5A00_0002);
    chk(rdData == 32'h4000_0002, "R4 polarity low", rdData, 32'h4000_0002);
    doWrite(32'h8A00_0004);
    chk(rdData == 32'h0000_0004, "R5 open-drain", rdData, 32'h0000_0004);

    // R10: retrigger + width write during pulse
    measure(1'b0, 1'b1, 32'h0000_0009, len);
    chk(len == 5, "R10 retrigger ignored", len, 5);
    chk(rdData == 32'h0000_0009, "R10 mid-pulse write stored", rdData, 32'h0000_0009);
    measure(1'b0, 1'b0, '0, len);
    chk(len == 10, "R10 new width next pulse", len, 10);

    // R10: write in same cycle as trigger uses old width (9)
    @(negedge clk); expire = 1; wrEn = 1; wrData = 32'h0000_0001;
    @(negedge clk); expire = 0; wrEn = 0; wrData = '0;
    len = 0;
    while (pulseLevel == 1'b0 && len < 5000) begin len++; @(negedge clk); end
    chk(len == 10, "R10 same-cycle write", len, 10);

    // sparse ticks, active high push-pull, model-compared each cycle (R3 R8 R9)
    tickDiv = 3;
    doWrite(32'hA500_0002);
    doWrite(32'hA800_0002);
    measure(1'b1, 1'b0, '0, len);
    chk(len >= 7 && len <= 9, "R3 sparse ticks", len, 8);
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule